// File: doc/BRIEF.md
# In-Service Register and End-of-Interrupt Unit

This block holds the in-service state of an eight-level interrupt controller, together with a rotation pointer that names the current lowest-priority level. Priority runs upward from the level just above that pointer and wraps from 7 to 0. The request resolver grants a level, and on the first acknowledge pulse of a cycle the in-service bit for that level is set. Software then ends the service routine by writing a 3-bit command made of rotate, select and end-of-interrupt bits plus a 3-bit level. Depending on the code, the command clears an in-service bit, moves the rotation pointer, or does both.

A configuration input turns on automatic end of interrupt. In that mode a non-specific clear happens on the falling edge of the last acknowledge pulse, which is the third pulse in three-pulse mode and the second pulse in two-pulse mode. A command turns on the rotate-in-automatic-mode flag. While that flag is set, the automatically cleared level also becomes the lowest priority. While special mask mode is active, a non-specific clear passes over in-service bits whose levels are masked.

Top module: `isr_eoi_unit`

## Requirements
- R1: After reset the in-service vector is 0x00, the lowest-priority level is 7, and both the rotate-in-automatic flag and the registered automatic-mode flag are 0.
- R2: On the rising edge of the first acknowledge pulse of a cycle, bit `grant_lvl_i` of the in-service vector is set. The change is visible after that clock edge. Later pulses of the same cycle do not set a bit.
- R3: Command code {R,SL,EOI}=001 (non-specific) clears the set in-service bit that has the highest priority, where priority starts at level (lowest+1) mod 8 and counts upward. If no bit is set, all state is left unchanged.
- R4: Command code 011 (specific) clears only in-service bit `cmd_lvl_i`.
- R5: Command code 101 clears the highest-priority set in-service bit and makes that level the lowest priority. If no bit is set, nothing changes.
- R6: Command code 100 sets the rotate-in-automatic flag and command code 000 clears it. The flag is visible one cycle after the write.
- R7: Command code 110 sets the lowest-priority level to `cmd_lvl_i` and leaves the in-service vector unchanged.
- R8: Command code 111 clears in-service bit `cmd_lvl_i` and sets the lowest-priority level to `cmd_lvl_i` in the same cycle.
- R9: When automatic mode is enabled, a non-specific clear happens on the falling edge of the last acknowledge pulse. That is the third pulse when `ack_two_i`=0 and the second pulse when `ack_two_i`=1. Earlier falling edges clear nothing.
- R10: When an automatic clear happens with the rotate-in-automatic flag set, the cleared level becomes the lowest priority.
- R11: When `spec_mask_i`=1, a non-specific clear passes over in-service bits whose `mask_i` bit is 1. When `spec_mask_i`=0, the mask has no effect on clearing.
- R12: `aeoi_en_o` follows `auto_eoi_i` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_we_i | input | 1 | Command write strobe, one cycle |
| cmd_rot_i | input | 1 | Command rotate bit (R) |
| cmd_sel_i | input | 1 | Command select-level bit (SL) |
| cmd_eoi_i | input | 1 | Command end-of-interrupt bit (EOI) |
| cmd_lvl_i | input | 3 | Command level field |
| ack_i | input | 1 | Acknowledge pulse train, active high, synchronous |
| ack_two_i | input | 1 | 1 selects two pulses per cycle, 0 selects three |
| grant_lvl_i | input | 3 | Level granted by the resolver |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt enable |
| spec_mask_i | input | 1 | Special mask mode active |
| mask_i | input | 8 | Per-level mask bits |
| isr_o | output | 8 | In-service vector |
| lowest_o | output | 3 | Current lowest-priority level |
| rot_aeoi_o | output | 1 | Rotate-in-automatic flag |
| aeoi_en_o | output | 1 | Registered automatic-mode flag |

## Verification
The bench drives a non-specific clear while the pointer has been rotated away from 7. A design that searched in fixed order would then clear the wrong bit. It also issues non-specific and rotating clears with no bit set, which a faulty design would answer by moving the pointer or clearing level 0. In both pulse modes it samples the in-service vector after every acknowledge falling edge, which exposes a clear on the wrong pulse. Finally it sets a mask bit with special mask mode on and then off, to show that a masked bit is skipped only while the mode is active.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // Command codes in {R, SL, EOI} order
    typedef enum logic [2:0] {
        CMD_ROT_OFF  = 3'b000,
        CMD_NS_EOI   = 3'b001,
        CMD_NOP      = 3'b010,
        CMD_SP_EOI   = 3'b011,
        CMD_ROT_ON   = 3'b100,
        CMD_ROT_NS   = 3'b101,
        CMD_SET_PRI  = 3'b110,
        CMD_ROT_SP   = 3'b111
    } cmd_e;

    typedef struct packed {
        logic clr_pick;   // clear highest-priority eligible bit
        logic clr_named;  // clear the bit named by the level field
        logic rot_pick;   // picked level becomes lowest
        logic rot_named;  // named level becomes lowest
        logic flag_on;
        logic flag_off;
    } cmd_act_t;

endpackage

// File: rtl/isr_cmd_dec.sv
module isr_cmd_dec
    import isr_pkg::*;
(
    input  logic     rot_i,
    input  logic     sel_i,
    input  logic     eoi_i,
    output cmd_act_t act_o
);
    cmd_e code;

    always_comb begin
        code  = cmd_e'({rot_i, sel_i, eoi_i});
        act_o = '0;
        case (code)
            CMD_NS_EOI:  act_o.clr_pick = 1'b1;
            CMD_SP_EOI:  act_o.clr_named = 1'b1;
            CMD_ROT_NS: begin
                act_o.clr_pick = 1'b1;
                act_o.rot_pick = 1'b1;
            end
            CMD_ROT_ON:  act_o.flag_on = 1'b1;
            CMD_ROT_OFF: act_o.flag_off = 1'b1;
            CMD_SET_PRI: act_o.rot_named = 1'b1;
            CMD_ROT_SP: begin
                act_o.clr_named = 1'b1;
                act_o.rot_named = 1'b1;
            end
            default: act_o = '0;
        endcase
    end
endmodule

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
    parameter int NUM_LVL = 8,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] cand_i,
    input  logic [LVL_W-1:0]   lowest_i,
    output logic               found_o,
    output logic [LVL_W-1:0]   idx_o
);
    // Walk from lowest priority to highest so the last hit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = NUM_LVL - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(lowest_i) + 1 + k) % NUM_LVL;
            if (cand_i[pos]) begin
                found_o = 1'b1;
                idx_o   = LVL_W'(pos);
            end
        end
    end
endmodule

// File: rtl/isr_ack_seq.sv
module isr_ack_seq #(
    parameter int LONG_SEQ  = 3,
    parameter int SHORT_SEQ = 2,
    localparam int CNT_W = $clog2(LONG_SEQ + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ack_i,
    input  logic two_i,
    output logic first_o,
    output logic last_o
);
    typedef struct packed {
        logic             ack;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q, d;
    logic rise, fall;
    logic [CNT_W-1:0] need;

    always_comb begin
        rise    = ack_i & ~q.ack;
        fall    = ~ack_i & q.ack;
        need    = two_i ? CNT_W'(SHORT_SEQ) : CNT_W'(LONG_SEQ);
        first_o = rise && (q.cnt == '0);
        last_o  = fall && (q.cnt == need - 1'b1);
        d       = q;
        d.ack   = ack_i;
        if (fall) begin
            d.cnt = last_o ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/isr_eoi_unit.sv
module isr_eoi_unit
    import isr_pkg::*;
#(
    parameter int NUM_LVL = 8,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmd_we_i,
    input  logic               cmd_rot_i,
    input  logic               cmd_sel_i,
    input  logic               cmd_eoi_i,
    input  logic [LVL_W-1:0]   cmd_lvl_i,
    input  logic               ack_i,
    input  logic               ack_two_i,
    input  logic [LVL_W-1:0]   grant_lvl_i,
    input  logic               auto_eoi_i,
    input  logic               spec_mask_i,
    input  logic [NUM_LVL-1:0] mask_i,
    output logic [NUM_LVL-1:0] isr_o,
    output logic [LVL_W-1:0]   lowest_o,
    output logic               rot_aeoi_o,
    output logic               aeoi_en_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0] isr;
        logic [LVL_W-1:0]   low;
        logic               rot_aeoi;
        logic               aeoi_en;
    } state_t;

    state_t   q, d;
    cmd_act_t act;
    logic     ack_first, ack_last;
    logic     pick_found;
    logic [LVL_W-1:0]   pick_idx;
    logic [NUM_LVL-1:0] eligible;

    isr_cmd_dec dec_i (
        .rot_i (cmd_rot_i),
        .sel_i (cmd_sel_i),
        .eoi_i (cmd_eoi_i),
        .act_o (act)
    );

    isr_ack_seq #(.LONG_SEQ(3), .SHORT_SEQ(2)) seq_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ack_i   (ack_i),
        .two_i   (ack_two_i),
        .first_o (ack_first),
        .last_o  (ack_last)
    );

    assign eligible = q.isr & ~(spec_mask_i ? mask_i : '0);

    isr_prio_pick #(.NUM_LVL(NUM_LVL)) pick_i (
        .cand_i   (eligible),
        .lowest_i (q.low),
        .found_o  (pick_found),
        .idx_o    (pick_idx)
    );

    // A command write takes precedence over an automatic clear in the same cycle.
    always_comb begin
        d         = q;
        d.aeoi_en = auto_eoi_i;
        if (ack_first) begin
            d.isr[grant_lvl_i] = 1'b1;
        end
        if (cmd_we_i) begin
            if (act.clr_pick && pick_found) begin
                d.isr[pick_idx] = 1'b0;
                if (act.rot_pick) d.low = pick_idx;
            end
            if (act.clr_named) d.isr[cmd_lvl_i] = 1'b0;
            if (act.rot_named) d.low = cmd_lvl_i;
            if (act.flag_on)   d.rot_aeoi = 1'b1;
            if (act.flag_off)  d.rot_aeoi = 1'b0;
        end else if (ack_last && q.aeoi_en && pick_found) begin
            d.isr[pick_idx] = 1'b0;
            if (q.rot_aeoi) d.low = pick_idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.isr      <= '0;
            q.low      <= LVL_W'(NUM_LVL - 1);
            q.rot_aeoi <= 1'b0;
            q.aeoi_en  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign isr_o      = q.isr;
    assign lowest_o   = q.low;
    assign rot_aeoi_o = q.rot_aeoi;
    assign aeoi_en_o  = q.aeoi_en;
endmodule

// File: rtl/isr_eoi_chk.sv
module isr_eoi_chk #(
    parameter int NUM_LVL = 8,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cmd_we_i,
    input logic               cmd_rot_i,
    input logic               cmd_sel_i,
    input logic               cmd_eoi_i,
    input logic [LVL_W-1:0]   cmd_lvl_i,
    input logic               ack_i,
    input logic               ack_two_i,
    input logic [LVL_W-1:0]   grant_lvl_i,
    input logic               auto_eoi_i,
    input logic               spec_mask_i,
    input logic [NUM_LVL-1:0] mask_i,
    input logic [NUM_LVL-1:0] isr_o,
    input logic [LVL_W-1:0]   lowest_o,
    input logic               rot_aeoi_o,
    input logic               aeoi_en_o
);
    logic [2:0] code;
    assign code = {cmd_rot_i, cmd_sel_i, cmd_eoi_i};

    // R7
    set_pri_keeps_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code == 3'b110 && !ack_i) |=> $stable(isr_o));

    // R7
    set_pri_moves_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code == 3'b110) |=> (lowest_o == $past(cmd_lvl_i)));

    // R4
    spec_eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code == 3'b011 && !ack_i) |=>
        (isr_o == ($past(isr_o) & ~(NUM_LVL'(1) << $past(cmd_lvl_i)))));

    // R6
    rot_flag_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code == 3'b100) |=> rot_aeoi_o);

    // R6
    rot_flag_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code == 3'b000) |=> !rot_aeoi_o);

    // R3
    ns_empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code[1:0] == 2'b01 && isr_o == '0 && !ack_i) |=>
        ($stable(isr_o) && $stable(lowest_o)));

    // R5
    ns_clear_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && code[1:0] == 2'b01 && isr_o != '0 && !ack_i) |=>
        ($countones(isr_o) == $countones($past(isr_o)) - 1));

    // R12
    aeoi_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (aeoi_en_o == $past(auto_eoi_i)));
endmodule

bind isr_eoi_unit isr_eoi_chk #(.NUM_LVL(NUM_LVL)) chk_i (.*);

// File: tb/isr_eoi_unit_tb.sv
module isr_eoi_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0, cmd_rot = 1'b0, cmd_sel = 1'b0, cmd_eoi = 1'b0;
    logic [2:0] cmd_lvl = '0;
    logic       ack = 1'b0, ack_two = 1'b0;
    logic [2:0] grant = '0;
    logic       auto_eoi = 1'b0, spec_mask = 1'b0;
    logic [7:0] mask = '0;
    logic [7:0] isr;
    logic [2:0] lowest;
    logic       rot_aeoi, aeoi_en;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    isr_eoi_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_rot_i(cmd_rot),
        .cmd_sel_i(cmd_sel), .cmd_eoi_i(cmd_eoi), .cmd_lvl_i(cmd_lvl),
        .ack_i(ack), .ack_two_i(ack_two), .grant_lvl_i(grant),
        .auto_eoi_i(auto_eoi), .spec_mask_i(spec_mask), .mask_i(mask),
        .isr_o(isr), .lowest_o(lowest), .rot_aeoi_o(rot_aeoi), .aeoi_en_o(aeoi_en)
    );

    // kind: 0 = command, 1 = full acknowledge cycle with grant = lvl
    typedef struct packed {
        logic       kind;
        logic [2:0] code;
        logic [2:0] lvl;
        logic [7:0] exp_isr;
        logic [2:0] exp_low;
        logic       exp_rot;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'b000, 3'd3, 8'h08, 3'd7, 1'b0, 4'd2},  // R2
        '{1'b1, 3'b000, 3'd5, 8'h28, 3'd7, 1'b0, 4'd2},  // R2
        '{1'b1, 3'b000, 3'd1, 8'h2A, 3'd7, 1'b0, 4'd2},  // R2
        '{1'b0, 3'b001, 3'd0, 8'h28, 3'd7, 1'b0, 4'd3},  // R3
        '{1'b0, 3'b011, 3'd5, 8'h08, 3'd7, 1'b0, 4'd4},  // R4
        '{1'b1, 3'b000, 3'd6, 8'h48, 3'd7, 1'b0, 4'd2},  // R2
        '{1'b0, 3'b101, 3'd0, 8'h40, 3'd3, 1'b0, 4'd5},  // R5
        '{1'b1, 3'b000, 3'd2, 8'h44, 3'd3, 1'b0, 4'd2},  // R2
        '{1'b0, 3'b001, 3'd0, 8'h04, 3'd3, 1'b0, 4'd3},  // R3 rotated search
        '{1'b0, 3'b110, 3'd1, 8'h04, 3'd1, 1'b0, 4'd7},  // R7
        '{1'b0, 3'b111, 3'd2, 8'h00, 3'd2, 1'b0, 4'd8},  // R8
        '{1'b0, 3'b001, 3'd0, 8'h00, 3'd2, 1'b0, 4'd3},  // R3 empty
        '{1'b0, 3'b101, 3'd0, 8'h00, 3'd2, 1'b0, 4'd5},  // R5 empty
        '{1'b0, 3'b100, 3'd0, 8'h00, 3'd2, 1'b1, 4'd6},  // R6 on
        '{1'b0, 3'b000, 3'd0, 8'h00, 3'd2, 1'b0, 4'd6}   // R6 off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] code, input logic [2:0] lvl);
        @(negedge clk);
        {cmd_rot, cmd_sel, cmd_eoi} = code;
        cmd_lvl = lvl;
        cmd_we  = 1'b1;
        @(negedge clk);
        cmd_we  = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack_cycle(input logic [2:0] g);
        grant = g;
        repeat (ack_two ? 2 : 3) pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 isr", 32'(isr), 32'h00);
        check("R1 lowest", 32'(lowest), 32'd7);
        check("R1 rot flag", 32'(rot_aeoi), 32'd0);
        check("R1 auto flag", 32'(aeoi_en), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].kind) ack_cycle(VECS[i].lvl);
            else              send_cmd(VECS[i].code, VECS[i].lvl);
            check($sformatf("R%0d vec%0d isr", VECS[i].req, i), 32'(isr), 32'(VECS[i].exp_isr));
            check($sformatf("R%0d vec%0d lowest", VECS[i].req, i), 32'(lowest), 32'(VECS[i].exp_low));
            check($sformatf("R%0d vec%0d rot", VECS[i].req, i), 32'(rot_aeoi), 32'(VECS[i].exp_rot));
        end

        // R12 registered automatic flag
        @(negedge clk);
        auto_eoi = 1'b1;
        check("R12 before edge", 32'(aeoi_en), 32'd0);
        @(negedge clk);
        check("R12 after edge", 32'(aeoi_en), 32'd1);

        // R9 three-pulse mode, grant 4, pointer at 2
        ack_two = 1'b0;
        grant = 3'd4;
        pulse();
        check("R9 3p after pulse1", 32'(isr), 32'h10);
        pulse();
        check("R9 3p after pulse2", 32'(isr), 32'h10);
        pulse();
        check("R9 3p after pulse3", 32'(isr), 32'h00);
        check("R9 3p lowest kept", 32'(lowest), 32'd2);

        // R9 two-pulse mode, grant 6
        ack_two = 1'b1;
        grant = 3'd6;
        pulse();
        check("R9 2p after pulse1", 32'(isr), 32'h40);
        pulse();
        check("R9 2p after pulse2", 32'(isr), 32'h00);

        // R10 rotate in automatic mode
        send_cmd(3'b100, 3'd0);
        ack_cycle(3'd5);
        check("R10 isr", 32'(isr), 32'h00);
        check("R10 lowest", 32'(lowest), 32'd5);
        send_cmd(3'b000, 3'd0);

        // R11 special mask, pointer at 5: priority 6,7,0,1,2,...
        auto_eoi = 1'b0;
        ack_two = 1'b0;
        @(negedge clk);
        ack_cycle(3'd1);
        ack_cycle(3'd2);
        check("R11 setup", 32'(isr), 32'h06);
        mask = 8'h02;
        spec_mask = 1'b1;
        send_cmd(3'b001, 3'd0);
        check("R11 masked bit skipped", 32'(isr), 32'h02);
        spec_mask = 1'b0;
        send_cmd(3'b001, 3'd0);
        check("R11 mode off clears", 32'(isr), 32'h00);
        ack_cycle(3'd1);
        ack_cycle(3'd2);
        send_cmd(3'b001, 3'd0);
        check("R11 mask ignored when off", 32'(isr), 32'h04);
        check("R11 lowest kept", 32'(lowest), 32'd5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule